// File: doc/BRIEF.md
# Tagged Multi-Line Receive Silo

This block is the receive storage of a sixteen-line serial multiplexer. Each line's receiver hands over a character together with its parity and framing error indications. Characters from all lines collect in one shared first-in first-out store. Each stored entry is tagged with the number of the line that produced it. A host pulls entries out one 16-bit word per read of the receive-character register. The top bit of that word tells the host whether it got a character, so it can keep reading until it sees a word with the top bit clear.

Every line has a one-entry holding register in front of the store. When several lines deliver in the same cycle, the lowest-numbered waiting line moves into the store first, one per cycle. A character that reaches a line whose holding register is still occupied is lost. The next entry to enter the store carries an overrun mark.

A programmable fill level raises a storage alarm. The alarm and the store's non-empty status combine with two enables to drive one interrupt output. A master-clear command returns everything to the reset state.

The fill state is tracked by a three-state machine:
- `SILO_EMPTY`. A write moves it to `SILO_PARTIAL` (transition *first_write*).
- `SILO_PARTIAL`. A write that brings the count to DEPTH moves it to `SILO_FULL` (*fill_up*). A read that brings the count to 0 moves it back to `SILO_EMPTY` (*drain_out*).
- `SILO_FULL`. A read moves it to `SILO_PARTIAL` (*first_free*).
- Reset or master clear returns the machine to `SILO_EMPTY` from any state (*clear*).

Top module: `tagged_rx_silo`

## Requirements
- R1: A read at address 1 while the store holds an entry returns the following word:
  - bit 15 = 1;
  - bits 7:0 = the character;
  - bits 11:8 = the line number;
  - bit 12 = the parity error flag pushed with the character;
  - bit 13 = the framing error flag pushed with the character;
  - bit 14 = the overrun mark.
- R2: A read at address 1 while the store is empty returns 16'h0000 and changes no state. A later push and read behave normally.
- R3: Entries leave in the order they entered the store. Each read at address 1 of a non-empty store removes exactly one entry.
- R4: When several lines push in the same cycle, the store takes their characters one per cycle in ascending line order.
- R5: The store holds DEPTH (64) entries. While it is full, holding registers are not drained. A push to a line whose holding register is occupied and is not moving into the store that cycle is discarded.
- R6: After a discarded push, the next entry written into the store has bit 14 set. Entries written after that one have bit 14 clear.
- R7: The status word read at address 0 has the following bits:
  - bit 7 is 1 exactly when the store is non-empty;
  - bit 14 (alarm) is 1 exactly when the alarm level is non-zero and the entry count is at least that level;
  - bit 6 and bit 12 read back the receive and storage interrupt enables.
- R8: The interrupt output follows these rules:
  - it is set when bit 12 is set and the alarm is active;
  - it is set when bit 6 is set and the alarm is active, provided the level is non-zero;
  - it is set when bit 6 is set and the store is non-empty, provided the level is zero.
- R9: A write to address 0 with bit 11 set is a master clear. Its other bits are ignored. It empties the store and every holding register, drops any pending overrun mark, and zeroes both enables and the alarm level (read at address 2). Bit 11 reads as 0.
- R10: After reset, reads at addresses 0, 1 and 2 all return 0, and the interrupt output is low.
- R11: A push sampled at clock edge t is written into the store at edge t+1 at the earliest. It is visible through status bit 7 only after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_push | input | NUM_LINES | Per-line character strobe |
| line_char | input | NUM_LINES*8 | Per-line character, line i in bits 8i+7:8i |
| line_perr | input | NUM_LINES | Per-line parity error flag |
| line_ferr | input | NUM_LINES | Per-line framing error / break flag |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops at address 1) |
| reg_addr | input | 2 | 0 status/control, 1 receive character, 2 alarm level |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |

## Verification
The overrun path is the hardest case to reach. It needs all 64 entries occupied, every holding register filled behind the full store, and one more push arriving on a line that is already waiting. The bench fills the store from a rotating line sequence, then loads all sixteen holding registers in one cycle, then pushes a second character onto line 3. While draining all 80 resulting entries, it confirms the following:
- the overrun mark lands only on the line-0 entry that enters first;
- the line-3 entry keeps its original character.

Master clear gets a similar treatment: it is issued one cycle after a sixteen-line burst, so holding registers still have work pending when it lands.

// File: rtl/silo_pkg.sv
package silo_pkg;

    localparam int CHAR_W = 8;
    localparam int LINE_W = 4;

    // Register addresses
    localparam logic [1:0] ADDR_CSR   = 2'd0;
    localparam logic [1:0] ADDR_RCHAR = 2'd1;
    localparam logic [1:0] ADDR_LEVEL = 2'd2;

    // Status/control bit positions
    localparam int CSR_RIE   = 6;
    localparam int CSR_RDY   = 7;
    localparam int CSR_CLEAR = 11;
    localparam int CSR_SIE   = 12;
    localparam int CSR_ALARM = 14;

    typedef struct packed {
        logic              ovr;
        logic              ferr;
        logic              perr;
        logic [LINE_W-1:0] line;
        logic [CHAR_W-1:0] ch;
    } silo_entry_t;

    typedef enum logic [1:0] {
        SILO_EMPTY,
        SILO_PARTIAL,
        SILO_FULL
    } silo_state_t;

endpackage

// File: rtl/silo_line_hold.sv
module silo_line_hold
    import silo_pkg::*;
#(
    parameter int NUM_LINES = 16
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic [NUM_LINES-1:0]        line_push,
    input  logic [NUM_LINES*CHAR_W-1:0] line_char,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic                        accept,
    output logic                        wr_valid,
    output silo_entry_t                 wr_entry
);

    logic [NUM_LINES-1:0] hold_v;
    logic [CHAR_W-1:0]    hold_ch [NUM_LINES];
    logic [NUM_LINES-1:0] hold_pe;
    logic [NUM_LINES-1:0] hold_fe;
    logic [NUM_LINES-1:0] grant;
    logic [NUM_LINES-1:0] drop;
    logic                 ovr_pend;

    // Lowest-numbered occupied holding register wins when the store has room
    assign grant    = accept ? (hold_v & (~hold_v + NUM_LINES'(1))) : '0;
    assign wr_valid = |grant;
    assign drop     = line_push & hold_v & ~grant;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            logic              v;
            logic [CHAR_W-1:0] c;
            logic              p;
            logic              f;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    v <= 1'b0;
                    c <= '0;
                    p <= 1'b0;
                    f <= 1'b0;
                end else if (clr) begin
                    v <= 1'b0;
                end else if (line_push[g] && (!v || grant[g])) begin
                    v <= 1'b1;
                    c <= line_char[g*CHAR_W +: CHAR_W];
                    p <= line_perr[g];
                    f <= line_ferr[g];
                end else if (grant[g]) begin
                    v <= 1'b0;
                end
            end

            assign hold_v[g]  = v;
            assign hold_ch[g] = c;
            assign hold_pe[g] = p;
            assign hold_fe[g] = f;
        end
    endgenerate

    always_comb begin
        wr_entry = '0;
        for (int i = 0; i < NUM_LINES; i++) begin
            if (grant[i]) begin
                wr_entry.ch   = hold_ch[i];
                wr_entry.perr = hold_pe[i];
                wr_entry.ferr = hold_fe[i];
                wr_entry.line = LINE_W'(i);
            end
        end
        wr_entry.ovr = ovr_pend;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovr_pend <= 1'b0;
        else if (clr)
            ovr_pend <= 1'b0;
        else
            ovr_pend <= (ovr_pend & ~wr_valid) | (|drop);
    end

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)) else $error("two lines granted"); // R4
    AST_NO_GRANT_WHEN_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |-> !wr_valid) else $error("write while store full"); // R5
    AST_DROP_MARKS: assert property (@(posedge clk) disable iff (!rst_n)
        ((|drop) && !clr) |=> ovr_pend) else $error("drop not remembered"); // R6

endmodule

// File: rtl/silo_fifo.sv
module silo_fifo
    import silo_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clr,
    input  logic                         wr,
    input  silo_entry_t                  wdata,
    input  logic                         rd,
    output silo_entry_t                  rdata,
    output logic                         empty,
    output logic                         full,
    output logic [$clog2(DEPTH+1)-1:0]   count
);

    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH+1);

    silo_entry_t       mem [DEPTH];
    logic [PTR_W-1:0]  wptr;
    logic [PTR_W-1:0]  rptr;
    silo_state_t       state;
    silo_state_t       state_nx;
    logic              do_wr;
    logic              do_rd;

    assign do_wr = wr && (state != SILO_FULL);
    assign do_rd = rd && (state != SILO_EMPTY);

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SILO_EMPTY: begin
                if (do_wr) state_nx = SILO_PARTIAL;               // first_write
            end
            SILO_PARTIAL: begin
                if (do_wr && !do_rd && count == CNT_W'(DEPTH-1))
                    state_nx = SILO_FULL;                          // fill_up
                else if (do_rd && !do_wr && count == CNT_W'(1))
                    state_nx = SILO_EMPTY;                         // drain_out
            end
            SILO_FULL: begin
                if (do_rd) state_nx = SILO_PARTIAL;               // first_free
            end
            default: state_nx = SILO_EMPTY;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SILO_EMPTY;
        else if (clr)
            state <= SILO_EMPTY;                                   // clear
        else
            state <= state_nx;
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else if (clr) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_wr)
                wptr <= (wptr == PTR_W'(DEPTH-1)) ? '0 : wptr + PTR_W'(1);
            if (do_rd)
                rptr <= (rptr == PTR_W'(DEPTH-1)) ? '0 : rptr + PTR_W'(1);
            if (do_wr && !do_rd)
                count <= count + CNT_W'(1);
            else if (do_rd && !do_wr)
                count <= count - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (do_wr) mem[wptr] <= wdata;
    end

    // Outputs
    always_comb begin
        empty = (state == SILO_EMPTY);
        full  = (state == SILO_FULL);
        rdata = mem[rptr];
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !do_wr) else $error("write into full store"); // R5
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(DEPTH)) else $error("count beyond depth"); // R5
    AST_EMPTY_MATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> (count == '0)) else $error("empty state with entries"); // R2
    AST_POP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (do_rd && !do_wr && !clr) |=> (count == $past(count) - CNT_W'(1))) else $error("pop not one entry"); // R3

endmodule

// File: rtl/tagged_rx_silo.sv
module tagged_rx_silo
    import silo_pkg::*;
#(
    parameter int NUM_LINES = 16,
    parameter int DEPTH     = 64
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NUM_LINES-1:0]        line_push,
    input  logic [NUM_LINES*CHAR_W-1:0] line_char,
    input  logic [NUM_LINES-1:0]        line_perr,
    input  logic [NUM_LINES-1:0]        line_ferr,
    input  logic                        reg_wr,
    input  logic                        reg_rd,
    input  logic [1:0]                  reg_addr,
    input  logic [15:0]                 reg_wdata,
    output logic [15:0]                 reg_rdata,
    output logic                        irq
);

    localparam int CNT_W = $clog2(DEPTH+1);

    logic             clr;
    logic             rie;
    logic             sie;
    logic [CNT_W-1:0] level;
    logic             pop;
    logic             wr_valid;
    silo_entry_t      wr_entry;
    silo_entry_t      head;
    logic             empty;
    logic             full;
    logic [CNT_W-1:0] count;
    logic             alarm;
    logic             ready;

    assign clr   = reg_wr && (reg_addr == ADDR_CSR) && reg_wdata[CSR_CLEAR];
    assign pop   = reg_rd && (reg_addr == ADDR_RCHAR) && !empty;
    assign alarm = (level != '0) && (count >= level);
    assign ready = (level == '0) ? !empty : alarm;
    assign irq   = (rie && ready) || (sie && alarm);

    silo_line_hold #(.NUM_LINES(NUM_LINES)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (clr),
        .line_push (line_push),
        .line_char (line_char),
        .line_perr (line_perr),
        .line_ferr (line_ferr),
        .accept    (!full),
        .wr_valid  (wr_valid),
        .wr_entry  (wr_entry)
    );

    silo_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (clr),
        .wr    (wr_valid),
        .wdata (wr_entry),
        .rd    (pop),
        .rdata (head),
        .empty (empty),
        .full  (full),
        .count (count)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
            level <= '0;
        end else if (clr) begin
            rie   <= 1'b0;
            sie   <= 1'b0;
            level <= '0;
        end else if (reg_wr) begin
            if (reg_addr == ADDR_CSR) begin
                rie <= reg_wdata[CSR_RIE];
                sie <= reg_wdata[CSR_SIE];
            end
            if (reg_addr == ADDR_LEVEL)
                level <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CSR: begin
                reg_rdata[CSR_RIE]   = rie;
                reg_rdata[CSR_RDY]   = !empty;
                reg_rdata[CSR_SIE]   = sie;
                reg_rdata[CSR_ALARM] = alarm;
            end
            ADDR_RCHAR: begin
                if (!empty)
                    reg_rdata = {1'b1, head.ovr, head.ferr, head.perr, head.line, head.ch};
            end
            ADDR_LEVEL: reg_rdata = 16'(level);
            default:    reg_rdata = '0;
        endcase
    end

    AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (empty && !irq)) else $error("master clear left state"); // R9
    AST_IRQ_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (rie || sie)) else $error("interrupt without enable"); // R8
    AST_EMPTY_READ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == ADDR_RCHAR && empty && !wr_valid && !clr) |=> empty) else $error("empty read changed store"); // R2

endmodule

// File: tb/tb_tagged_rx_silo.sv
`timescale 1ns/1ps
module tb_tagged_rx_silo;

    localparam int NL = 16;
    localparam int DP = 64;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [NL-1:0]   push, pe, fe;
    logic [NL*8-1:0] chars;
    logic            reg_wr, reg_rd;
    logic [1:0]      reg_addr;
    logic [15:0]     reg_wdata, reg_rdata;
    logic            irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    tagged_rx_silo #(.NUM_LINES(NL), .DEPTH(DP)) dut (
        .clk(clk), .rst_n(rst_n), .line_push(push), .line_char(chars),
        .line_perr(pe), .line_ferr(fe), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic peek(input logic [1:0] a, output logic [15:0] v);
        reg_addr = a;
        reg_rd   = 1'b0;
        #0.5;
        v = reg_rdata;
    endtask

    task automatic pop(output logic [15:0] v);
        reg_addr = 2'd1;
        reg_rd   = 1'b1;
        #0.5;
        v = reg_rdata;
        tick();
        reg_rd = 1'b0;
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        reg_addr  = a;
        reg_wdata = d;
        reg_wr    = 1'b1;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic push_lines(input logic [NL-1:0] m);
        push = m;
        tick();
        push = '0;
    endtask

    function automatic logic [15:0] word(input int line, input int ch, input bit o, input bit f, input bit p);
        return 16'h8000 | (16'(o) << 14) | (16'(f) << 13) | (16'(p) << 12) | (16'(line) << 8) | 16'(ch & 8'hFF);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        rst_n = 1'b0; push = '0; pe = '0; fe = '0; chars = '0;
        reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R10 reset state
        peek(2'd0, v); check("R10 csr", v, 16'h0000);
        peek(2'd1, v); check("R10 rchar", v, 16'h0000);
        peek(2'd2, v); check("R10 level", v, 16'h0000);
        check("R10 irq", {15'b0, irq}, 16'h0000);

        // R11 latency and R1 parity tag
        chars[5*8 +: 8] = 8'hA7; pe[5] = 1'b1;
        push_lines(16'h0020);
        pe = '0;
        peek(2'd0, v); check("R11 not yet stored", v, 16'h0000);
        tick();
        peek(2'd0, v); check("R11 stored", v, 16'h0080);
        pop(v); check("R1 parity word", v, word(5, 8'hA7, 0, 0, 1));

        // R2 empty read
        pop(v); check("R2 empty word", v, 16'h0000);
        peek(2'd0, v); check("R2 still empty", v, 16'h0000);
        chars[12*8 +: 8] = 8'h5A; fe[12] = 1'b1;
        push_lines(16'h1000);
        fe = '0;
        tick();
        pop(v); check("R1 R2 framing word after empty read", v, word(12, 8'h5A, 0, 1, 0));
        peek(2'd0, v); check("R3 popped one", v, 16'h0000);

        // R4 simultaneous bursts with R7/R8 sweeps
        for (int trial = 0; trial < 2; trial++) begin
            for (int i = 0; i < NL; i++) begin
                chars[i*8 +: 8] = 8'((i * 7 + 3 + trial * 100) & 255);
                fe[i] = (trial == 0) && (i % 2 == 1);
                pe[i] = (trial == 1) && (i % 2 == 0);
            end
            push_lines('1);
            pe = '0; fe = '0;
            repeat (17) tick();
            if (trial == 0) begin
                for (int lv = 0; lv <= 20; lv++) begin
                    wr_reg(2'd2, 16'(lv));
                    peek(2'd0, v);
                    check("R7 alarm level sweep", v, 16'h0080 | ((lv != 0 && 16 >= lv) ? 16'h4000 : 16'h0));
                end
                for (int cfg = 0; cfg < 12; cfg++) begin
                    int lv;
                    bit r, s, al, ex;
                    r  = cfg[0];
                    s  = cfg[1];
                    lv = (cfg / 4 == 0) ? 0 : ((cfg / 4 == 1) ? 8 : 20);
                    al = (lv != 0) && (16 >= lv);
                    ex = (r && (lv == 0 ? 1'b1 : al)) || (s && al);
                    wr_reg(2'd2, 16'(lv));
                    wr_reg(2'd0, (16'(r) << 6) | (16'(s) << 12));
                    check("R8 irq combination", {15'b0, irq}, {15'b0, ex});
                end
                wr_reg(2'd2, 16'd8);
                wr_reg(2'd0, 16'h0040);
            end
            for (int i = 0; i < NL; i++) begin
                if (trial == 0) begin
                    peek(2'd0, v);
                    check("R7 alarm while draining", v, 16'h00C0 | ((16 - i >= 8) ? 16'h4000 : 16'h0));
                    check("R8 irq while draining", {15'b0, irq}, {15'b0, (16 - i >= 8)});
                end
                pop(v);
                check("R4 ascending line order", v,
                      word(i, i * 7 + 3 + trial * 100, 0, (trial == 0) && (i % 2 == 1), (trial == 1) && (i % 2 == 0)));
            end
            wr_reg(2'd0, 16'h0000);
            wr_reg(2'd2, 16'h0000);
        end

        // R5 fill to depth, R6 overrun mark
        for (int k = 0; k < DP; k++) begin
            chars[(k % NL)*8 +: 8] = 8'(k);
            push_lines(NL'(1) << (k % NL));
        end
        repeat (2) tick();
        wr_reg(2'd2, 16'(DP));
        peek(2'd0, v); check("R5 full at depth", v, 16'h4080);
        for (int i = 0; i < NL; i++) chars[i*8 +: 8] = 8'(8'h80 + i);
        push_lines('1);
        chars[3*8 +: 8] = 8'hFF;
        push_lines(16'h0008);
        repeat (3) tick();
        for (int k = 0; k < DP; k++) begin
            pop(v); check("R5 R3 full store order", v, word(k % NL, k, 0, 0, 0));
        end
        for (int i = 0; i < NL; i++) begin
            pop(v); check("R6 overrun only on next entry", v, word(i, 8'h80 + i, i == 0, 0, 0));
        end
        pop(v); check("R5 drained", v, 16'h0000);

        // R9 master clear with holding registers still loaded
        wr_reg(2'd2, 16'd5);
        wr_reg(2'd0, 16'h1040);
        for (int i = 0; i < NL; i++) chars[i*8 +: 8] = 8'(i);
        push_lines('1);
        wr_reg(2'd0, 16'h1840);
        repeat (20) tick();
        peek(2'd0, v); check("R9 csr cleared", v, 16'h0000);
        peek(2'd1, v); check("R9 store empty", v, 16'h0000);
        peek(2'd2, v); check("R9 level cleared", v, 16'h0000);
        check("R9 irq low", {15'b0, irq}, 16'h0000);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule